// File: doc/BRIEF.md
# Two-Register I2C Configuration Slave for a Clock Generator

This block is an I2C target that holds two 8-bit control registers for a clock generator. It oversamples the serial clock and data lines with a fast system clock. It recognises one write address byte and one read address byte. From the register contents it drives three plain control pins: a primary clock enable, a secondary clock enable and a frequency select for the secondary output, which picks between 48 MHz and 72 MHz.

Every transfer names a starting register index and a byte count. A write sends the index, then the count, then the data bytes. A read first writes the index, then issues a repeated start with the read address. The block answers with a count byte and then the register contents, beginning at the index. The bus runs at standard-mode speed, so the system clock is many times faster than the bit rate.

The control pins are level outputs with no handshake. They change only when a data byte is acknowledged. The block has no streaming data path, so it has no valid/ready interface.

Top module: `cfg_i2c_slave`

## Requirements
- R1: While reset is held, register 0 becomes 0x6F and register 1 becomes 0x3F. As a result, pri_clk_en=1, sec_clk_en=1, sel_48m=0 and sda_oe=0.
- R2: The block acknowledges only the address bytes 0xD4 (write) and 0xD5 (read). Any other address byte is not acknowledged, and the bytes that follow it up to the next STOP are neither acknowledged nor written.
- R3: A write transfer is START, 0xD4, index N, count X, then data bytes. The block acknowledges each of these bytes and stores data byte k in register N+k while k < X.
- R4: A read transfer is START, 0xD4, index N, repeated START, then 0xD5. The block returns a count byte equal to 2−N (0 when N > 1), followed by register N, register N+1 and so on, for as long as the master acknowledges.
- R5: An index above 1, or a count that runs past register 1, is still acknowledged. A write to a location beyond register 1 is dropped, and a read of such a location returns 0x00.
- R6: Data bytes sent after the count is used up, and all data bytes of a transfer with count 0, are acknowledged but not stored.
- R7: pri_clk_en is bit 0 of register 0 and sec_clk_en is bit 1 of register 0. sel_48m is bit 7 of register 1, where 1 selects 48 MHz and 0 selects 72 MHz.
- R8: A register changes when its data byte is acknowledged, and only while SCL is low. A transfer stopped partway keeps the bytes that were already acknowledged and drops the partial byte.
- R9: A STOP, or a START in the middle of a byte, ends the current transfer. No partial byte is written, and the slave releases SDA after a STOP.
- R10: SDA is open-drain. sda_oe=1 pulls the line low. The block never begins pulling SDA low while SCL is high, and it releases SDA whenever it is not acknowledging or sending a 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, sampled |
| sda_i | input | 1 | Serial data line, sampled |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| pri_clk_en | output | 1 | Primary clock enable |
| sec_clk_en | output | 1 | Secondary clock enable |
| sel_48m | output | 1 | Secondary frequency select, 1 = 48 MHz |

## Verification
The assertions check on every cycle that:
- the control pins reach their reset values during reset;
- the control pins never change while SCL is high;
- SDA is never newly pulled low during an SCL-high phase;
- every register write coincides with an acknowledge;
- SDA is released after each STOP.

Only the bench's bus transactions can show what is stored and returned. These include the count byte of each read, the handling of indexes and counts outside the map, the rejection of foreign addresses, and the outcome of transfers cut short by a STOP or a repeated START.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RACK,
    PH_TX,
    PH_TACK
  } phase_t;

  typedef enum logic [1:0] {
    RB_ADDR,
    RB_INDEX,
    RB_COUNT,
    RB_DATA
  } rxrole_t;

  function automatic logic [7:0] sat_inc8(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_now   = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  // data edges with the clock held high mark bus conditions
  assign start_evt = scl_now & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_now & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs #(
  parameter int NREG = 2,
  parameter logic [NREG*8-1:0] RST_VAL = {8'h3F, 8'h6F}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_flat[g*8 +: 8] <= RST_VAL[g*8 +: 8];
      else if (wr_en && wr_idx == 8'(g))
        regs_flat[g*8 +: 8] <= wr_data;
    end
  end

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter int         NREG      = 2,
  parameter logic [6:0] DEV_ADDR7 = 7'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [NREG*8-1:0] regs_flat,
  output logic              wr_en,
  output logic [7:0]        wr_idx,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);

  localparam logic [7:0] WR_BYTE = {DEV_ADDR7, 1'b0};
  localparam logic [7:0] RD_BYTE = {DEV_ADDR7, 1'b1};
  localparam logic [7:0] NREG_B  = 8'(NREG);

  phase_t     phase;
  rxrole_t    role;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, ptr, remain;
  logic       rd_mode, m_ack;
  logic [7:0] rd_byte, cnt_byte;
  logic       byte_done, in_map;

  assign in_map    = ptr < NREG_B;
  assign cnt_byte  = in_map ? (NREG_B - ptr) : 8'h00;
  assign byte_done = (phase == PH_RX) && scl_fall && (bit_cnt == 4'd8)
                     && !start_evt && !stop_evt;

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == 8'(i)) rd_byte = regs_flat[i*8 +: 8];
  end

  // commit lands in the same cycle the acknowledge begins
  assign wr_en   = byte_done && (role == RB_DATA) && (remain != 8'd0) && in_map;
  assign wr_idx  = ptr;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      role    <= RB_ADDR;
      bit_cnt <= 4'd0;
      shreg   <= 8'h00;
      ptr     <= 8'h00;
      remain  <= 8'h00;
      rd_mode <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_RX;
      role    <= RB_ADDR;
      bit_cnt <= 4'd0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            phase  <= PH_RACK;
            sda_oe <= 1'b1;
            unique case (role)
              RB_ADDR: begin
                if (shreg == WR_BYTE) begin
                  role    <= RB_INDEX;
                  rd_mode <= 1'b0;
                end else if (shreg == RD_BYTE) begin
                  rd_mode <= 1'b1;
                end else begin
                  phase  <= PH_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              RB_INDEX: begin
                ptr  <= shreg;
                role <= RB_COUNT;
              end
              RB_COUNT: begin
                remain <= shreg;
                role   <= RB_DATA;
              end
              RB_DATA: begin
                if (remain != 8'd0) remain <= remain - 8'd1;
                ptr <= sat_inc8(ptr);
              end
            endcase
          end
        end
        PH_RACK: begin
          if (scl_fall) begin
            bit_cnt <= 4'd0;
            if (rd_mode) begin
              shreg  <= cnt_byte;
              sda_oe <= ~cnt_byte[7];
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_TACK;
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              sda_oe  <= ~shreg[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        PH_TACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall) begin
            if (m_ack) begin
              shreg   <= rd_byte;
              sda_oe  <= ~rd_byte[7];
              ptr     <= sat_inc8(ptr);
              bit_cnt <= 4'd0;
              phase   <= PH_TX;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NREG        = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR7   = 7'h6A,
  parameter logic [7:0] REG0_RST    = 8'h6F,
  parameter logic [7:0] REG1_RST    = 8'h3F,
  parameter int         PRI_BIT     = 0,
  parameter int         SEC_BIT     = 1,
  parameter int         SEL_BIT     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic pri_clk_en,
  output logic sec_clk_en,
  output logic sel_48m
);

  localparam logic [NREG*8-1:0] RST_FLAT = (NREG*8)'({REG1_RST, REG0_RST});

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [7:0] wr_idx, wr_data;
  logic [NREG*8-1:0] regs_flat;

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfg_i2c_engine #(.NREG(NREG), .DEV_ADDR7(DEV_ADDR7)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .regs_flat(regs_flat), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_i2c_regs #(.NREG(NREG), .RST_VAL(RST_FLAT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  assign pri_clk_en = regs_flat[PRI_BIT];
  assign sec_clk_en = regs_flat[SEC_BIT];
  assign sel_48m    = regs_flat[8 + SEL_BIT];

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic pri_clk_en,
  input logic sec_clk_en,
  input logic sel_48m,
  input logic stop_evt,
  input logic wr_en
);

  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    !rst_n |=> (pri_clk_en && sec_clk_en && !sel_48m && !sda_oe));

  // R8
  ctrl_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pri_clk_en, sec_clk_en, sel_48m}) |-> !scl_i);

  // R10
  no_pull_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_oe)) |-> !sda_oe);

  // R8
  write_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R9
  release_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .pri_clk_en(pri_clk_en), .sec_clk_en(sec_clk_en), .sel_48m(sel_48m),
  .stop_evt(stop_evt), .wr_en(wr_en)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;

  localparam int Q = 15;
  localparam int NVEC = 8;
  // {index, count, data bytes sent, d0, d1, expected reg0, expected reg1}
  localparam logic [55:0] VEC [0:NVEC-1] = '{
    {8'h00, 8'h01, 8'd1, 8'h6D, 8'h00, 8'h6D, 8'h3F},
    {8'h01, 8'h01, 8'd1, 8'hBF, 8'h00, 8'h6D, 8'hBF},
    {8'h00, 8'h02, 8'd2, 8'h6F, 8'h3F, 8'h6F, 8'h3F},
    {8'h01, 8'h02, 8'd2, 8'hA5, 8'h11, 8'h6F, 8'hA5},
    {8'h05, 8'h01, 8'd1, 8'h00, 8'h00, 8'h6F, 8'hA5},
    {8'h00, 8'h01, 8'd2, 8'h12, 8'h34, 8'h12, 8'hA5},
    {8'h00, 8'h00, 8'd1, 8'h77, 8'h00, 8'h12, 8'hA5},
    {8'h00, 8'h02, 8'd2, 8'h6C, 8'hBE, 8'h6C, 8'hBE}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_bus, sda_oe, pri_clk_en, sec_clk_en, sel_48m;
  int nchk = 0, nerr = 0;
  logic [7:0] rbuf [0:3];

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  cfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pri_clk_en(pri_clk_en), .sec_clk_en(sec_clk_en), .sel_48m(sel_48m)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(); scl = 1'b1; wq();
      b[i] = sda_bus;
      wq(); scl = 1'b0; wq();
    end
    m_sda = ~ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; m_sda = 1'b1; wq();
  endtask

  task automatic i2c_write(input logic [7:0] idx, input logic [7:0] cnt, input int nd,
                           input logic [7:0] d0, input logic [7:0] d1, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    bus_start();
    send_byte(8'hD4, a); all_ack &= a;
    send_byte(idx, a);   all_ack &= a;
    send_byte(cnt, a);   all_ack &= a;
    if (nd > 0) begin send_byte(d0, a); all_ack &= a; end
    if (nd > 1) begin send_byte(d1, a); all_ack &= a; end
    bus_stop();
  endtask

  // rbuf[0] = count byte, rbuf[1..nd] = data
  task automatic i2c_read(input logic [7:0] idx, input int nd, output logic all_ack);
    logic a;
    logic [7:0] b;
    all_ack = 1'b1;
    bus_start();
    send_byte(8'hD4, a); all_ack &= a;
    send_byte(idx, a);   all_ack &= a;
    bus_rstart();
    send_byte(8'hD5, a); all_ack &= a;
    recv_byte(nd > 0, b); rbuf[0] = b;
    for (int i = 0; i < nd; i++) begin
      recv_byte(i < nd - 1, b); rbuf[i+1] = b;
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h1, 8'h0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic ok, a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    // R1 reset values at the ports
    check("R1 pri_clk_en", {7'd0, pri_clk_en}, 8'h01);
    check("R1 sec_clk_en", {7'd0, sec_clk_en}, 8'h01);
    check("R1 sel_48m", {7'd0, sel_48m}, 8'h00);
    check("R10 sda released in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    i2c_read(8'h00, 2, ok);
    check("R4 read acks", {7'd0, ok}, 8'h01);
    check("R4 count from 0", rbuf[0], 8'h02);
    check("R1 reg0 default", rbuf[1], 8'h6F);
    check("R1 reg1 default", rbuf[2], 8'h3F);

    // table walk: R3 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [55:0] e;
      e = VEC[v];
      i2c_write(e[55:48], e[47:40], int'(e[39:32]), e[31:24], e[23:16], ok);
      check($sformatf("R3 R5 R6 write acks vec%0d", v), {7'd0, ok}, 8'h01);
      check($sformatf("R7 pri vec%0d", v), {7'd0, pri_clk_en}, {7'd0, e[8]});
      check($sformatf("R7 sec vec%0d", v), {7'd0, sec_clk_en}, {7'd0, e[9]});
      check($sformatf("R7 sel48 vec%0d", v), {7'd0, sel_48m}, {7'd0, e[7]});
      check($sformatf("R10 idle release vec%0d", v), {7'd0, sda_oe}, 8'h00);
      i2c_read(8'h00, 2, ok);
      check($sformatf("R3 R5 R6 reg0 vec%0d", v), rbuf[1], e[15:8]);
      check($sformatf("R3 R5 R6 reg1 vec%0d", v), rbuf[2], e[7:0]);
    end

    // R4 R5: read from index 1 runs past the map
    i2c_read(8'h01, 2, ok);
    check("R4 count from 1", rbuf[0], 8'h01);
    check("R4 reg1 data", rbuf[1], 8'hBE);
    check("R5 read past map", rbuf[2], 8'h00);

    // R4 R5: index beyond map
    i2c_read(8'h04, 1, ok);
    check("R5 index beyond acked", {7'd0, ok}, 8'h01);
    check("R4 count beyond map", rbuf[0], 8'h00);
    check("R5 data beyond map", rbuf[1], 8'h00);

    // R2 foreign address
    bus_start();
    send_byte(8'hA0, a);
    check("R2 foreign addr nack", {7'd0, a}, 8'h00);
    send_byte(8'h00, a);
    check("R2 following byte nack", {7'd0, a}, 8'h00);
    send_byte(8'h11, a);
    bus_stop();
    i2c_read(8'h00, 2, ok);
    check("R2 reg0 untouched", rbuf[1], 8'h6C);
    check("R2 reg1 untouched", rbuf[2], 8'hBE);

    // R9 repeated start in the middle of a data byte
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_bits(8'hFF, 5);
    bus_rstart();
    send_byte(8'hD5, a);
    check("R9 read after abort acked", {7'd0, a}, 8'h01);
    recv_byte(1'b1, b);
    check("R9 count after abort", b, 8'h02);
    recv_byte(1'b0, b);
    check("R9 partial byte dropped", b, 8'h6C);
    bus_stop();
    check("R9 release after stop", {7'd0, sda_oe}, 8'h00);

    // R1 reset in mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pri after reset", {7'd0, pri_clk_en}, 8'h01);
    check("R1 sel48 after reset", {7'd0, sel_48m}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 stop partway: first data byte kept, second partial byte dropped
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    send_byte(8'h40, a);
    check("R8 data ack", {7'd0, a}, 8'h01);
    check("R8 pri updated at ack", {7'd0, pri_clk_en}, 8'h00);
    check("R8 sec updated at ack", {7'd0, sec_clk_en}, 8'h00);
    send_bits(8'h80, 4);
    bus_stop();
    i2c_read(8'h00, 2, ok);
    check("R8 reg0 kept", rbuf[1], 8'h40);
    check("R8 reg1 unchanged", rbuf[2], 8'h3F);
    check("R8 sel48 unchanged", {7'd0, sel_48m}, 8'h00);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule